// File: doc/BRIEF.md
# Processor Status Register with Stack Pointer Banking and Branch Condition Decode

This block keeps a 16-bit processor status word and applies flag updates to it, one update per clock. The instruction sequencer gives each update as a strobe, an operation code and its operands. The available updates are: write one flag, derive negative/zero from a sized result, clear carry and overflow, write extend and carry together, derive flags from a logical result, load only the condition-code byte, load the whole word, and replace the interrupt priority mask. The new status word appears on the clock edge after the strobe.

The block also owns the active stack pointer and two banked copies of it, one for user mode and one for supervisor mode. Any update that writes the supervisor bit first parks the current stack pointer in the copy that belongs to the mode being left. It then makes the copy that belongs to the mode being entered the active pointer. The sequencer can also overwrite the active pointer directly. Separately, a 4-bit condition selector is decoded against the current flags into one true/false line that branch and set-on-condition logic can use.

Top module: `psr_core`

## Requirements
- R1: After reset the status word is 0x2700 (supervisor bit 13 set, mask bits 10..8 equal to 7, every other bit zero) and the active stack pointer and both banked copies are zero.
- R2: Flag positions are carry bit 0, overflow bit 1, zero bit 2, negative bit 3, extend bit 4, supervisor bit 13 and trace bit 15. The single-flag operations write `op_flag` into exactly one of these bits and leave all other bits unchanged. Their codes are 1 for carry, 2 for overflow, 3 for zero, 4 for negative, 5 for extend, 6 for trace and 7 for supervisor.
- R3: Operation 9 sets zero when the sized result is all zeros and sets negative to the sized result's top bit. `res_size` selects the size: 0 means bits 7..0, 1 means bits 15..0, and 2 or 3 means the full result. Extend, overflow, carry and the system byte keep their values.
- R4: Operation 10 clears carry and overflow and, in the same cycle, sets negative and zero from the sized result exactly as R3 does.
- R5: Operation 11 clears carry and overflow and changes no other bit.
- R6: Operation 8 writes `op_flag` into both extend and carry.
- R7: Operation 12 copies `op_word` bits 4..0 into status bits 4..0, forces bits 7..5 to zero and keeps bits 15..8.
- R8: Operation 13 loads `op_word` into the status word. Only the implemented bits are kept (mask 0xA71F); all others read zero.
- R9: Operation 14 places `op_mask` into bits 10..8 and keeps all other bits.
- R10: When operation 7 or operation 13 is applied, the active stack pointer is first stored into the banked copy of the old mode (bit 13 before the update). The active stack pointer is then loaded from the banked copy of the new mode. If the mode does not change, the active pointer keeps its value.
- R11: `sp_wr` loads `sp_wdata` into the active stack pointer on the next edge. If a supervisor-writing operation is applied in the same cycle, the written value is the one saved into the old mode's banked copy.
- R12: `cond_true` is a combinational decode of the current status word. The `cond_sel` values 0 to 15 mean, in order: always true, always false, higher (!C&!Z), lower-or-same (C|Z), carry clear, carry set, not equal (!Z), equal (Z), overflow clear, overflow set, plus (!N), minus (N), greater-or-equal !(N^V), less-than (N^V), greater-than !(N^V)&!Z, and less-or-equal (N^V)|Z.
- R13: When `op_valid` is low, and also for operation codes 0 and 15, the status word does not change.
- R14: Status bits 14, 12, 11 and 7..5 always read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Applies the update named by `op_code` on this edge |
| op_code | input | 4 | Update operation code (see requirements) |
| op_flag | input | 1 | Value for single-flag and extend/carry updates |
| op_result | input | DATA_W | Result that negative/zero are derived from |
| res_size | input | 2 | Size of `op_result`: 0 byte, 1 word, 2/3 full |
| op_word | input | 16 | Value for byte and word loads |
| op_mask | input | 3 | New interrupt priority mask |
| sp_wr | input | 1 | Direct write of the active stack pointer |
| sp_wdata | input | SP_W | Value for the direct write |
| cond_sel | input | 4 | Condition selector |
| sr | output | 16 | Current status word |
| sp_active | output | SP_W | Current active stack pointer |
| cond_true | output | 1 | Selected condition evaluated on `sr` |

## Verification
The banked stack copies cannot be seen directly. Each one only shows up on `sp_active` when the mode changes into it. A wrong save path therefore stays hidden until a later mode change, possibly several updates after the fault. The stimulus opens with a directed sequence that puts distinct values into both banks, swaps modes back and forth, applies a same-mode supervisor write, and combines a direct pointer write with a mode change in one cycle. After that, a long constrained-random run mixes full-word loads with pointer writes, so that the bench model's banks are compared against the design's on every later swap.

// File: rtl/psr_pkg.sv
package psr_pkg;

  localparam int SR_W = 16;

  localparam int BIT_C = 0;
  localparam int BIT_V = 1;
  localparam int BIT_Z = 2;
  localparam int BIT_N = 3;
  localparam int BIT_X = 4;
  localparam int BIT_S = 13;
  localparam int BIT_T = 15;
  localparam int MASK_LO = 8;
  localparam int MASK_HI = 10;

  localparam logic [SR_W-1:0] SR_IMPL  = 16'hA71F;
  localparam logic [SR_W-1:0] SR_RESET = 16'h2700;

  typedef enum logic [3:0] {
    OP_NOP      = 4'd0,
    OP_SET_C    = 4'd1,
    OP_SET_V    = 4'd2,
    OP_SET_Z    = 4'd3,
    OP_SET_N    = 4'd4,
    OP_SET_X    = 4'd5,
    OP_SET_T    = 4'd6,
    OP_SET_S    = 4'd7,
    OP_SET_XC   = 4'd8,
    OP_SET_NZ   = 4'd9,
    OP_LOGIC_NZ = 4'd10,
    OP_CLR_CV   = 4'd11,
    OP_LOAD_CCR = 4'd12,
    OP_LOAD_SR  = 4'd13,
    OP_SET_MASK = 4'd14,
    OP_RSVD     = 4'd15
  } psr_op_e;

  typedef enum logic [3:0] {
    CC_T  = 4'd0,  CC_F  = 4'd1,  CC_HI = 4'd2,  CC_LS = 4'd3,
    CC_CC = 4'd4,  CC_CS = 4'd5,  CC_NE = 4'd6,  CC_EQ = 4'd7,
    CC_VC = 4'd8,  CC_VS = 4'd9,  CC_PL = 4'd10, CC_MI = 4'd11,
    CC_GE = 4'd12, CC_LT = 4'd13, CC_GT = 4'd14, CC_LE = 4'd15
  } cond_e;

  // nzvc = {N, Z, V, C}
  function automatic logic cond_of(input logic [3:0] nzvc, input cond_e sel);
    logic n, z, v, c, lt;
    n  = nzvc[3];
    z  = nzvc[2];
    v  = nzvc[1];
    c  = nzvc[0];
    lt = n ^ v;
    case (sel)
      CC_T:    cond_of = 1'b1;
      CC_F:    cond_of = 1'b0;
      CC_HI:   cond_of = ~c & ~z;
      CC_LS:   cond_of = c | z;
      CC_CC:   cond_of = ~c;
      CC_CS:   cond_of = c;
      CC_NE:   cond_of = ~z;
      CC_EQ:   cond_of = z;
      CC_VC:   cond_of = ~v;
      CC_VS:   cond_of = v;
      CC_PL:   cond_of = ~n;
      CC_MI:   cond_of = n;
      CC_GE:   cond_of = ~lt;
      CC_LT:   cond_of = lt;
      CC_GT:   cond_of = ~lt & ~z;
      default: cond_of = lt | z;
    endcase
  endfunction

endpackage

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
  import psr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              op_flag,
  input  logic [DATA_W-1:0] op_result,
  input  logic [1:0]        res_size,
  input  logic [15:0]       op_word,
  input  logic [2:0]        op_mask,
  input  logic [SR_W-1:0]   sr_q,
  output logic [SR_W-1:0]   sr_d,
  output logic              s_write
);

  localparam int BYTE_W = 8;
  localparam int WORD_W = 16;

  // returns {N, Z} of the result at the selected size
  function automatic logic [1:0] sized_nz(input logic [DATA_W-1:0] r,
                                          input logic [1:0] sz);
    logic n, z;
    case (sz)
      2'd0: begin
        n = r[BYTE_W-1];
        z = (r[BYTE_W-1:0] == '0);
      end
      2'd1: begin
        n = r[WORD_W-1];
        z = (r[WORD_W-1:0] == '0);
      end
      default: begin
        n = r[DATA_W-1];
        z = (r == '0);
      end
    endcase
    sized_nz = {n, z};
  endfunction

  psr_op_e op;
  logic [1:0] nz;

  assign op = psr_op_e'(op_code);
  assign nz = sized_nz(op_result, res_size);

  always_comb begin
    sr_d    = sr_q;
    s_write = 1'b0;
    if (op_valid) begin
      case (op)
        OP_SET_C:  sr_d[BIT_C] = op_flag;
        OP_SET_V:  sr_d[BIT_V] = op_flag;
        OP_SET_Z:  sr_d[BIT_Z] = op_flag;
        OP_SET_N:  sr_d[BIT_N] = op_flag;
        OP_SET_X:  sr_d[BIT_X] = op_flag;
        OP_SET_T:  sr_d[BIT_T] = op_flag;
        OP_SET_S: begin
          sr_d[BIT_S] = op_flag;
          s_write     = 1'b1;
        end
        OP_SET_XC: begin
          sr_d[BIT_X] = op_flag;
          sr_d[BIT_C] = op_flag;
        end
        OP_SET_NZ: begin
          sr_d[BIT_N] = nz[1];
          sr_d[BIT_Z] = nz[0];
        end
        OP_LOGIC_NZ: begin
          sr_d[BIT_N] = nz[1];
          sr_d[BIT_Z] = nz[0];
          sr_d[BIT_V] = 1'b0;
          sr_d[BIT_C] = 1'b0;
        end
        OP_CLR_CV: begin
          sr_d[BIT_V] = 1'b0;
          sr_d[BIT_C] = 1'b0;
        end
        OP_LOAD_CCR: sr_d = {sr_q[15:8], 3'b000, op_word[4:0]};
        OP_LOAD_SR: begin
          sr_d    = op_word & SR_IMPL;
          s_write = 1'b1;
        end
        OP_SET_MASK: sr_d[MASK_HI:MASK_LO] = op_mask;
        default: sr_d = sr_q;
      endcase
    end
  end

endmodule

// File: rtl/psr_sp_bank.sv
module psr_sp_bank #(
  parameter int SP_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sp_wr,
  input  logic [SP_W-1:0] sp_wdata,
  input  logic            s_write,
  input  logic            s_old,
  input  logic            s_new,
  output logic [SP_W-1:0] sp_q
);

  localparam int BANKS = 2;

  logic [SP_W-1:0] bank_q [BANKS];
  logic [SP_W-1:0] sp_cur;
  logic            mode_change;

  assign sp_cur      = sp_wr ? sp_wdata : sp_q;
  assign mode_change = s_write && (s_old != s_new);

  // bank 0 = user copy, bank 1 = supervisor copy
  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        bank_q[g] <= '0;
      else if (s_write && (s_old == (g != 0)))
        bank_q[g] <= sp_cur;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sp_q <= '0;
    else if (mode_change)
      sp_q <= bank_q[s_new];
    else
      sp_q <= sp_cur;
  end

endmodule

// File: rtl/psr_cond.sv
module psr_cond
  import psr_pkg::*;
(
  input  logic [3:0] nzvc,
  input  logic [3:0] cond_sel,
  output logic       cond_true
);

  assign cond_true = cond_of(nzvc, cond_e'(cond_sel));

endmodule

// File: rtl/psr_core.sv
module psr_core
  import psr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SP_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic              op_flag,
  input  logic [DATA_W-1:0] op_result,
  input  logic [1:0]        res_size,
  input  logic [15:0]       op_word,
  input  logic [2:0]        op_mask,
  input  logic              sp_wr,
  input  logic [SP_W-1:0]   sp_wdata,
  input  logic [3:0]        cond_sel,
  output logic [15:0]       sr,
  output logic [SP_W-1:0]   sp_active,
  output logic              cond_true
);

  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;
  logic            s_write;
  logic [3:0]      nzvc;

  psr_flag_unit #(.DATA_W(DATA_W)) flag_i (
    .op_valid  (op_valid),
    .op_code   (op_code),
    .op_flag   (op_flag),
    .op_result (op_result),
    .res_size  (res_size),
    .op_word   (op_word),
    .op_mask   (op_mask),
    .sr_q      (sr_q),
    .sr_d      (sr_d),
    .s_write   (s_write)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr_q <= SR_RESET;
    else
      sr_q <= sr_d;
  end

  psr_sp_bank #(.SP_W(SP_W)) bank_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .sp_wr    (sp_wr),
    .sp_wdata (sp_wdata),
    .s_write  (s_write),
    .s_old    (sr_q[BIT_S]),
    .s_new    (sr_d[BIT_S]),
    .sp_q     (sp_active)
  );

  assign nzvc = {sr_q[BIT_N], sr_q[BIT_Z], sr_q[BIT_V], sr_q[BIT_C]};

  psr_cond cond_i (
    .nzvc      (nzvc),
    .cond_sel  (cond_sel),
    .cond_true (cond_true)
  );

  assign sr = sr_q;

endmodule

// File: rtl/psr_core_chk.sv
module psr_core_chk #(
  parameter int SP_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            op_valid,
  input logic [3:0]      op_code,
  input logic [2:0]      op_mask,
  input logic            sp_wr,
  input logic            s_write,
  input logic [3:0]      cond_sel,
  input logic            cond_true,
  input logic [15:0]     sr,
  input logic [SP_W-1:0] sp_active
);

  p_nz_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd9) |=> ({sr[15:4], sr[1:0]} == $past({sr[15:4], sr[1:0]})));

  p_logic_clears_cv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd10) |=> (sr[1:0] == 2'b00));

  p_xc_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd8) |=> (sr[4] == sr[0]));

  p_ccr_keeps_sys_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd12) |=> (sr[15:8] == $past(sr[15:8])));

  p_mask_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == 4'd14) |=> (sr[10:8] == $past(op_mask)));

  p_sp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_write && !sp_wr) |=> $stable(sp_active));

  p_cond_const_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel[3:1] == 3'b000) |-> (cond_true == ~cond_sel[0]));

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(sr));

  p_unimpl_zero_r14: assert property (@(posedge clk) disable iff (!rst_n)
    (sr & 16'h58E0) == 16'h0000);

endmodule

bind psr_core psr_core_chk #(.SP_W(SP_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .op_mask   (op_mask),
  .sp_wr     (sp_wr),
  .s_write   (s_write),
  .cond_sel  (cond_sel),
  .cond_true (cond_true),
  .sr        (sr),
  .sp_active (sp_active)
);

// File: tb/psr_core_tb_top.sv
module psr_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam int N_RANDOM = 3000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [3:0]    op_code = '0;
  logic          op_flag = 1'b0;
  logic [DW-1:0] op_result = '0;
  logic [1:0]    res_size = '0;
  logic [15:0]   op_word = '0;
  logic [2:0]    op_mask = '0;
  logic          sp_wr = 1'b0;
  logic [AW-1:0] sp_wdata = '0;
  logic [3:0]    cond_sel = '0;
  logic [15:0]   sr;
  logic [AW-1:0] sp_active;
  logic          cond_true;

  int checks = 0;
  int failures = 0;

  logic [15:0]   m_sr;
  logic [AW-1:0] m_a7, m_usp, m_ssp;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_core #(.DATA_W(DW), .SP_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_flag(op_flag), .op_result(op_result), .res_size(res_size),
    .op_word(op_word), .op_mask(op_mask), .sp_wr(sp_wr), .sp_wdata(sp_wdata),
    .cond_sel(cond_sel), .sr(sr), .sp_active(sp_active), .cond_true(cond_true)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] tb_nz(input logic [DW-1:0] r, input logic [1:0] sz);
    logic [DW-1:0] keep;
    int bits;
    bits = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : DW;
    keep = (bits == DW) ? r : (r & ((32'd1 << bits) - 32'd1));
    return {((keep >> (bits - 1)) & 32'd1) != 0, keep == 0};
  endfunction

  function automatic logic [15:0] tb_next(input logic [15:0] s);
    logic [15:0] n;
    logic [1:0] nz;
    n = s;
    nz = tb_nz(op_result, res_size);
    if (op_valid) begin
      if (op_code >= 4'd1 && op_code <= 4'd5) n[op_code - 4'd1] = op_flag;
      else if (op_code == 4'd6) n[15] = op_flag;
      else if (op_code == 4'd7) n[13] = op_flag;
      else if (op_code == 4'd8) n = (s & ~16'h0011) | (op_flag ? 16'h0011 : 16'h0000);
      else if (op_code == 4'd9) n = (s & ~16'h000C) | {12'd0, nz, 2'b00};
      else if (op_code == 4'd10) n = (s & ~16'h000F) | {12'd0, nz, 2'b00};
      else if (op_code == 4'd11) n = s & ~16'h0003;
      else if (op_code == 4'd12) n = (s & 16'hFF00) | (op_word & 16'h001F);
      else if (op_code == 4'd13) n = op_word & 16'hA71F;
      else if (op_code == 4'd14) n = (s & ~16'h0700) | ({13'd0, op_mask} << 8);
    end
    return n;
  endfunction

  function automatic logic tb_cond(input logic [15:0] s, input logic [3:0] sel);
    logic c, v, z, n, r;
    c = s[0]; v = s[1]; z = s[2]; n = s[3];
    r = 1'b0;
    if (sel[3:1] == 3'd0) r = 1'b1;
    else if (sel[3:1] == 3'd1) r = !(c || z);
    else if (sel[3:1] == 3'd2) r = !c;
    else if (sel[3:1] == 3'd3) r = !z;
    else if (sel[3:1] == 3'd4) r = !v;
    else if (sel[3:1] == 3'd5) r = !n;
    else if (sel[3:1] == 3'd6) r = (n == v);
    else r = (n == v) && !z;
    return sel[0] ? !r : r;
  endfunction

  function automatic string req_of(input logic v, input logic [3:0] op);
    if (!v || op == 4'd0 || op == 4'd15) return "R13";
    if (op <= 4'd7) return "R2";
    case (op)
      4'd8: return "R6";
      4'd9: return "R3";
      4'd10: return "R4";
      4'd11: return "R5";
      4'd12: return "R7";
      4'd13: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step();
    logic [15:0] nsr;
    logic [AW-1:0] cur;
    bit swp;
    string sp_req;
    nsr = tb_next(m_sr);
    cur = sp_wr ? sp_wdata : m_a7;
    swp = op_valid && (op_code == 4'd7 || op_code == 4'd13);
    sp_req = (sp_wr && swp) ? "R11" : "R10";
    if (swp) begin
      if (m_sr[13]) m_ssp = cur; else m_usp = cur;
      cur = nsr[13] ? m_ssp : m_usp;
    end
    m_a7 = cur;
    m_sr = nsr;
    @(posedge clk);
    #1;
    check(req_of(op_valid, op_code), "sr", {16'd0, sr}, {16'd0, m_sr});
    check(sp_req, "sp_active", sp_active, m_a7);
    check("R12", "cond_true", {31'd0, cond_true}, {31'd0, tb_cond(m_sr, cond_sel)});
    check("R14", "unimplemented bits", {16'd0, sr & 16'h58E0}, 32'd0);
    op_valid = 1'b0;
    sp_wr = 1'b0;
  endtask

  task automatic drive(input logic [3:0] op, input logic fl, input logic [31:0] res,
                       input logic [1:0] sz, input logic [15:0] w, input logic [2:0] mk,
                       input logic wr, input logic [31:0] wd, input logic [3:0] cs);
    op_valid = 1'b1; op_code = op; op_flag = fl; op_result = res; res_size = sz;
    op_word = w; op_mask = mk; sp_wr = wr; sp_wdata = wd; cond_sel = cs;
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    m_sr = 16'h2700; m_a7 = '0; m_usp = '0; m_ssp = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset sr", {16'd0, sr}, 32'h0000_2700);
    check("R1", "reset sp", sp_active, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 R11: bank both copies with distinct values and swap between them
    drive(4'd0, 0, 0, 0, 0, 0, 1'b1, 32'h0000_1000, 4'd0);   // a7 = 0x1000 (supervisor)
    drive(4'd7, 0, 0, 0, 0, 0, 1'b0, 0, 4'd1);                // to user: ssp=0x1000, a7=usp=0
    drive(4'd0, 0, 0, 0, 0, 0, 1'b1, 32'h0000_2000, 4'd0);   // user a7 = 0x2000
    drive(4'd7, 1, 0, 0, 0, 0, 1'b0, 0, 4'd0);                // to supervisor: a7=0x1000
    drive(4'd7, 1, 0, 0, 0, 0, 1'b0, 0, 4'd0);                // same mode, unchanged
    drive(4'd13, 0, 0, 0, 16'h0000, 0, 1'b1, 32'h0000_3000, 4'd0); // R11: 0x3000 saved to ssp, a7=0x2000
    drive(4'd7, 1, 0, 0, 0, 0, 1'b0, 0, 4'd0);                // back: a7=0x3000
    // R3 R4 size corners
    drive(4'd9, 0, 32'hFFFF_FF00, 2'd0, 0, 0, 0, 0, 4'd7);    // byte zero
    drive(4'd9, 0, 32'h0000_8000, 2'd1, 0, 0, 0, 0, 4'd11);   // word negative
    drive(4'd10, 0, 32'h8000_0000, 2'd2, 0, 0, 0, 0, 4'd13);  // long negative
    drive(4'd13, 0, 0, 0, 16'hFFFF, 0, 0, 0, 4'd15);          // R8 full load
    drive(4'd12, 0, 0, 0, 16'h00E0, 0, 0, 0, 4'd2);           // R7 byte load
    drive(4'd14, 0, 0, 0, 0, 3'd2, 0, 0, 4'd14);              // R9
    drive(4'd15, 1, 0, 0, 16'hFFFF, 3'd7, 0, 0, 4'd3);        // R13 reserved

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] r;
      op_valid  = ($urandom % 8) != 0;
      op_code   = 4'($urandom);
      op_flag   = 1'($urandom);
      r = $urandom;
      case ($urandom % 4)
        0: op_result = 32'd0;
        1: op_result = r & 32'hFFFF_FF00;
        2: op_result = r & 32'hFFFF_0000;
        default: op_result = r;
      endcase
      res_size  = 2'($urandom);
      op_word   = 16'($urandom);
      op_mask   = 3'($urandom);
      sp_wr     = ($urandom % 3) == 0;
      sp_wdata  = $urandom;
      cond_sel  = 4'($urandom);
      step();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule